// File: doc/BRIEF.md
# Configurable-Width External Bus Sequencer

This block sits between a processor-side request port and a set of external memory or expansion banks that may each be 8, 16 or 32 bits wide. The processor side asks for either a single byte or a full 32-bit word. Each request names a bank and carries a 28-bit address. The block looks up the bank's width code and turns a word request into as many one-clock external cycles as that width needs. On every cycle it drives the address, the write lanes, one strobe and the bank's chip select. For reads it gathers the returned lanes into a little-endian word and hands that word back with a one-cycle done pulse.

Every bank's width code starts at zero, so the first fetches after power-on go to bank 0 at the width given by a strap pin. The strap is sampled while reset is held, and it flips the meaning of every width code. One width code selects a PC-card style mode. In that mode address bits 27:26 do not reach the bus. Instead they choose attribute memory, common memory or I/O space, and they also choose whether the access is 8 or 16 bits wide.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset, ready is 1, no strobe or chip select is active and every bank's width code is 00. With the strap low, a word read to bank 0 therefore takes one 32-bit cycle.
- R2: The strap is sampled only while rst_n is low. A change on strap_i after reset has no effect on any decode.
- R3: The effective code is the bank's 2-bit width code XOR {strap,strap}. Effective 00 means 32-bit, 01 means 16-bit, 10 means PC-card mode and 11 means 8-bit. The inversion applies to every bank.
- R4: In PC-card mode, ext_addr[25:0] follows the request address plus the sub-cycle offset and ext_addr[27:26] is 00. Request bits 27:26 choose the access: 00 is 8-bit attribute memory (ext_attr=1), 01 is 16-bit common memory, 10 is 8-bit I/O (ext_io=1) and 11 is 16-bit I/O (ext_io=1).
- R5: A word request ignores address bits 1:0. It runs 4, 2 or 1 cycles for widths 8, 16 or 32. Addresses rise from the aligned base in steps of the width. On a write cycle at byte offset n, ext_wdata carries the request word shifted right by 8*n.
- R6: For a word read, the lanes [w*8-1:0] returned at offset n are stored in rdata bits starting at 8*n, which gives a little-endian word.
- R7: A byte request takes exactly one cycle at the unmodified address. A write repeats data[7:0] on all four lanes. A read returns, zero-extended, the lane at (address mod width).
- R8: Each external cycle lasts one clock. During it exactly one of ext_rd or ext_wr is high, and ext_cs has only the bit of the request's bank set. done is a single-cycle pulse in the clock right after the last cycle, and rdata is valid while done is high.
- R9: ready is 1 only while idle. A req_valid that arrives while busy is ignored and causes no external cycle.
- R10: A pulse on cfg_wr loads cfg_code into the width code of bank cfg_sel. Requests accepted after the write use the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| strap_i | input | 1 | Boot-width strap, sampled during reset |
| cfg_wr | input | 1 | Width code write enable |
| cfg_sel | input | SW | Bank whose code is written |
| cfg_code | input | 2 | New width code |
| req_valid | input | 1 | Request strobe, taken when ready |
| req_word | input | 1 | 1 = word request, 0 = byte request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | SW | Target bank |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data (byte in bits 7:0) |
| ready | output | 1 | Idle, can accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read data |
| ext_addr | output | AW | External address |
| ext_wdata | output | 32 | External write lanes |
| ext_rdata | input | 32 | External read lanes |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |
| ext_cs | output | NBANK | Per-bank chip selects |
| ext_io | output | 1 | PC-card I/O space access |
| ext_attr | output | 1 | PC-card attribute memory access |

## Verification
Word reads and writes are sent to banks set to each of the four effective codes. This separates the 1-, 2- and 4-cycle splits, confirms the address steps and write-lane shifts, and checks that the read lanes are packed in order. Byte requests at odd and non-aligned addresses on 8-, 16- and 32-bit banks show the single-cycle path and the lane selection. The four PC-card address-type combinations tell attribute, common and I/O accesses apart. A second reset with the strap high shows that the same codes decode inverted on several banks, while a strap change after reset, a request during a busy sequence and a code rewrite show what must and must not change the decode.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int NBANK = 4,
  parameter int AW    = 28,
  localparam int SW   = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_i,
  input  logic             cfg_wr,
  input  logic [SW-1:0]    cfg_sel,
  input  logic [1:0]       cfg_code,
  input  logic             req_valid,
  input  logic             req_word,
  input  logic             req_write,
  input  logic [SW-1:0]    req_bank,
  input  logic [AW-1:0]    req_addr,
  input  logic [31:0]      req_wdata,
  output logic             ready,
  output logic             done,
  output logic [31:0]      rdata,
  output logic [AW-1:0]    ext_addr,
  output logic [31:0]      ext_wdata,
  input  logic [31:0]      ext_rdata,
  output logic             ext_rd,
  output logic             ext_wr,
  output logic [NBANK-1:0] ext_cs,
  output logic             ext_io,
  output logic             ext_attr
);

  logic [1:0]    cfg_q [NBANK];
  logic          strap_q;

  logic          busy, word_q, wr_q, io_q, attr_q;
  logic [1:0]    k_q, lg_q;
  logic [SW-1:0] bank_q;
  logic [AW-1:0] base_q;
  logic [31:0]   wd_q, rbuf_q, rnext;

  logic [1:0]    eff, lg_d, off, lane;
  logic          pc, acc, last;
  logic [AW-1:0] cur;
  logic [7:0]    byte_in;

  always_ff @(posedge clk)
    if (!rst_n) strap_q <= strap_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) cfg_q[i] <= 2'b00;
    end else if (cfg_wr) begin
      cfg_q[cfg_sel] <= cfg_code;
    end

  assign eff = cfg_q[req_bank] ^ {2{strap_q}};
  assign pc  = (eff == 2'b10);
  assign acc = req_valid && !busy;

  always_comb
    case (eff)
      2'b00:   lg_d = 2'd2;
      2'b01:   lg_d = 2'd1;
      2'b11:   lg_d = 2'd0;
      default: lg_d = {1'b0, req_addr[AW-2]};
    endcase

  assign off  = word_q ? (k_q << lg_q) : 2'b00;
  assign last = !word_q || (k_q == (2'b11 >> lg_q));
  assign cur  = word_q ? {base_q[AW-1:2], off} : base_q;
  assign lane = base_q[1:0] & {lg_q[1], lg_q != 2'd0};
  assign byte_in = ext_rdata[{lane, 3'b000} +: 8];

  always_comb begin
    rnext = rbuf_q;
    if (!word_q)
      rnext = {24'b0, byte_in};
    else
      case (lg_q)
        2'd0:    rnext[{off, 3'b000} +: 8]  = ext_rdata[7:0];
        2'd1:    rnext[{off, 3'b000} +: 16] = ext_rdata[15:0];
        default: rnext = ext_rdata;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      word_q <= 1'b0;
      wr_q   <= 1'b0;
      io_q   <= 1'b0;
      attr_q <= 1'b0;
      k_q    <= 2'd0;
      lg_q   <= 2'd0;
      bank_q <= '0;
      base_q <= '0;
      wd_q   <= '0;
      rbuf_q <= '0;
    end else begin
      done <= 1'b0;
      if (acc) begin
        busy   <= 1'b1;
        word_q <= req_word;
        wr_q   <= req_write;
        bank_q <= req_bank;
        lg_q   <= lg_d;
        k_q    <= 2'd0;
        wd_q   <= req_wdata;
        io_q   <= pc && req_addr[AW-1];
        attr_q <= pc && (req_addr[AW-1:AW-2] == 2'b00);
        base_q <= pc ? {2'b00, req_addr[AW-3:0]} : req_addr;
      end else if (busy) begin
        k_q    <= k_q + 2'd1;
        rbuf_q <= rnext;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end

  assign ready     = !busy;
  assign rdata     = rbuf_q;
  assign ext_addr  = busy ? cur : '0;
  assign ext_rd    = busy && !wr_q;
  assign ext_wr    = busy && wr_q;
  assign ext_cs    = busy ? (NBANK'(1) << bank_q) : '0;
  assign ext_io    = busy && io_q;
  assign ext_attr  = busy && attr_q;
  assign ext_wdata = (busy && wr_q) ? (word_q ? (wd_q >> {off, 3'b000}) : {4{wd_q[7:0]}}) : 32'b0;

endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk #(
  parameter int NBANK = 4,
  parameter int AW    = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             done,
  input logic             ext_rd,
  input logic             ext_wr,
  input logic [NBANK-1:0] ext_cs,
  input logic [AW-1:0]    ext_addr
);

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_rd, ext_wr}));

  a_r8_cs_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) |-> $countones(ext_cs) == 1);

  a_r8_no_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_rd || ext_wr) |-> ext_cs == '0);

  a_r9_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !(ext_rd || ext_wr));

  a_r8_done_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ext_rd || ext_wr));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    ((ext_rd && $past(ext_rd)) || (ext_wr && $past(ext_wr))) |-> ext_addr > $past(ext_addr));

endmodule

bind ext_bus_seq ext_bus_seq_chk #(.NBANK(NBANK), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .done(done),
  .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_cs(ext_cs), .ext_addr(ext_addr)
);

// File: tb/ext_bus_seq_tb.sv
module ext_bus_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NBANK = 4;
  localparam int AW = 28;

  logic clk = 0, rst_n = 0, strap_i = 0;
  logic cfg_wr = 0, req_valid = 0, req_word = 0, req_write = 0;
  logic [1:0] cfg_sel = 0, cfg_code = 0, req_bank = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic ready, done, ext_rd, ext_wr, ext_io, ext_attr;
  logic [31:0] rdata, ext_wdata, ext_rdata;
  logic [AW-1:0] ext_addr;
  logic [NBANK-1:0] ext_cs;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_seq #(.NBANK(NBANK), .AW(AW)) u_dut (.*);

  typedef struct {
    logic rd, wr, io, attr;
    logic [NBANK-1:0] cs;
    logic [AW-1:0] addr;
    logic [31:0] wd;
    string tag;
  } cyc_t;
  typedef struct { logic rd; logic [31:0] data; string tag; } fin_t;

  cyc_t cq[$];
  fin_t dq[$];
  int checks = 0, errors = 0, strobes = 0, cur_w = 4;
  logic [1:0] cfg_m [NBANK];
  logic strap_m = 0;
  logic prev_strobe = 0;

  function automatic logic [7:0] fb(logic [AW-1:0] x);
    return 8'(x * 37 + (x >> 5) + 5);
  endfunction

  always_comb begin
    logic [AW-1:0] al;
    al = ext_addr & ~AW'(cur_w - 1);
    for (int i = 0; i < 4; i++) ext_rdata[8*i +: 8] = fb(al + AW'(i));
  end

  task automatic check(bit ok, string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial forever begin
    @(posedge clk); #2;
    if (rst_n) begin
      if (ext_rd || ext_wr) begin
        strobes++;
        if (cq.size() == 0) check(0, "R9", "unexpected external cycle", {ext_addr}, 0);
        else begin
          cyc_t e;
          e = cq.pop_front();
          check({ext_rd, ext_wr, ext_io, ext_attr, ext_cs, ext_addr} == {e.rd, e.wr, e.io, e.attr, e.cs, e.addr},
                e.tag, "cycle rd/wr/io/attr/cs/addr",
                {ext_rd, ext_wr, ext_io, ext_attr, ext_cs, ext_addr}, {e.rd, e.wr, e.io, e.attr, e.cs, e.addr});
          if (e.wr) check(ext_wdata == e.wd, e.tag, "write lanes", ext_wdata, e.wd);
        end
      end
      if (done) begin
        check(prev_strobe && cq.size() == 0, "R8", "done right after last cycle", 0, 1);
        if (dq.size() == 0) check(0, "R8", "unexpected done", 1, 0);
        else begin
          fin_t f;
          f = dq.pop_front();
          if (f.rd) check(rdata == f.data, f.tag, "read data", rdata, f.data);
        end
      end
      prev_strobe = ext_rd || ext_wr;
    end
  end

  task automatic do_reset(logic s);
    @(negedge clk);
    rst_n = 0; strap_i = s;
    repeat (3) @(negedge clk);
    rst_n = 1; strap_m = s;
    for (int i = 0; i < NBANK; i++) cfg_m[i] = 2'b00;
    @(negedge clk);
    check(ready && !ext_rd && !ext_wr && ext_cs == 0 && !done, "R1", "reset idle state",
          {ready, ext_rd, ext_wr, ext_cs, done}, {1'b1, 1'b0, 1'b0, 4'b0, 1'b0});
  endtask

  task automatic set_cfg(int b, logic [1:0] c);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = 2'(b); cfg_code = c;
    @(negedge clk);
    cfg_wr = 0;
    cfg_m[b] = c;
  endtask

  task automatic expect_req(string tag, bit word, bit wr, int bank, logic [AW-1:0] a, logic [31:0] wd);
    logic [1:0] code;
    logic pc;
    int w;
    logic [AW-1:0] ea, base;
    fin_t f;
    code = cfg_m[bank] ^ {2{strap_m}};
    pc = (code == 2'b10);
    w = (code == 2'b00) ? 4 : (code == 2'b01) ? 2 : (code == 2'b11) ? 1 : (a[26] ? 2 : 1);
    ea = pc ? {2'b00, a[25:0]} : a;
    cur_w = w;
    f.rd = !wr; f.tag = tag;
    if (word) begin
      base = ea & ~AW'(3);
      for (int k = 0; k < 4 / w; k++) begin
        cyc_t c;
        c.rd = !wr; c.wr = wr; c.io = pc && a[27]; c.attr = pc && a[27:26] == 2'b00;
        c.cs = 4'(1 << bank); c.addr = base + AW'(k * w); c.wd = wd >> (8 * k * w); c.tag = tag;
        cq.push_back(c);
      end
      f.data = {fb(base + 3), fb(base + 2), fb(base + 1), fb(base)};
    end else begin
      cyc_t c;
      c.rd = !wr; c.wr = wr; c.io = pc && a[27]; c.attr = pc && a[27:26] == 2'b00;
      c.cs = 4'(1 << bank); c.addr = ea; c.wd = {4{wd[7:0]}}; c.tag = tag;
      cq.push_back(c);
      f.data = {24'b0, fb(ea)};
    end
    dq.push_back(f);
  endtask

  task automatic issue(bit word, bit wr, int bank, logic [AW-1:0] a, logic [31:0] wd);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1; req_word = word; req_write = wr; req_bank = 2'(bank); req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (cq.size() != 0 || dq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_req(string tag, bit word, bit wr, int bank, logic [AW-1:0] a, logic [31:0] wd);
    expect_req(tag, word, wr, bank, a, wd);
    issue(word, wr, bank, a, wd);
    wait_idle();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    do_reset(0);
    do_req("R1", 1, 0, 0, 28'h0000100, 0);
    strap_i = 1;
    do_req("R2", 1, 1, 0, 28'h0000200, 32'hA1B2C3D4);

    set_cfg(1, 2'b01);
    do_req("R5", 1, 1, 1, 28'h0000106, 32'h11223344);
    do_req("R6", 1, 0, 1, 28'h0000340, 0);
    set_cfg(2, 2'b11);
    do_req("R6", 1, 0, 2, 28'h0000483, 0);
    do_req("R5", 1, 1, 2, 28'h0000500, 32'hDEADBEEF);
    do_req("R7", 0, 0, 2, 28'h0000611, 0);
    do_req("R7", 0, 1, 2, 28'h0000613, 32'h000000C7);
    do_req("R7", 0, 0, 1, 28'h0000615, 0);
    do_req("R7", 0, 0, 0, 28'h0000717, 0);
    do_req("R7", 0, 1, 0, 28'h0000719, 32'h0000005A);

    set_cfg(3, 2'b10);
    do_req("R4", 1, 0, 3, 28'h0012340, 0);
    do_req("R4", 1, 0, 3, 28'h4012344, 0);
    do_req("R4", 1, 0, 3, 28'h8012348, 0);
    do_req("R4", 1, 0, 3, 28'hC01234C, 0);
    do_req("R4", 0, 1, 3, 28'h8000021, 32'h00000099);

    s0 = strobes;
    expect_req("R9", 1, 1, 2, 28'h0000800, 32'h01020304);
    issue(1, 1, 2, 28'h0000800, 32'h01020304);
    check(!ready, "R9", "ready while busy", ready, 0);
    req_valid = 1; req_word = 1; req_write = 0; req_bank = 0; req_addr = 28'h0000900;
    repeat (2) @(negedge clk);
    req_valid = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    check(strobes - s0 == 4, "R9", "cycles for busy-time request", strobes - s0, 4);

    set_cfg(2, 2'b00);
    s0 = strobes;
    do_req("R10", 1, 0, 2, 28'h0000A00, 0);
    check(strobes - s0 == 1, "R10", "cycle count after code rewrite", strobes - s0, 1);

    do_reset(1);
    s0 = strobes;
    do_req("R3", 1, 0, 0, 28'h0000B00, 0);
    check(strobes - s0 == 4, "R3", "inverted code 00 gives 8-bit", strobes - s0, 4);
    set_cfg(1, 2'b11);
    do_req("R3", 1, 0, 1, 28'h0000C00, 0);
    set_cfg(2, 2'b10);
    do_req("R3", 1, 1, 2, 28'h0000D00, 32'hCAFEF00D);
    set_cfg(3, 2'b01);
    do_req("R3", 1, 0, 3, 28'h4000E00, 0);

    check(cq.size() == 0 && dq.size() == 0, "R8", "scoreboard drained", cq.size() + dq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule